// File: doc/BRIEF.md
# 16-bit ALU with Carry Status Register

This block computes one of twenty-three operations on two 16-bit operands and keeps an 8-bit status register beside it. Bit 0 of that register is the carry flag, and the other bits hold whatever software last wrote. The operations are bitwise logic, shifts, wrapping arithmetic, a three-way compare, six relational predicates, and a boolean test with its negation. The result of the selected operation is always visible on a combinational output.

When the operation strobe is high, the next clock edge copies that result into a result register and applies the carry rule of the operation. Add and sub produce a fresh carry. Mul, div and mod clear it. Every other operation leaves the status register alone. An opcode above the defined range raises a one-cycle error pulse and changes neither register. A divide or modulo by zero returns 0 and raises its own one-cycle pulse.

The status register is also reached through a small register port with a 4-bit select. At select value 0xd a read returns the status register zero-extended to 16 bits, and a write loads the low 8 bits of the write data. The block accepts an operation on every cycle the strobe is high. There is no back-pressure, so a caller never waits.

Top module: `alu16_carry_unit`

## Requirements
- R1: With opcodes 0x00 to 0x06, `comb_result` is NOT A, A AND B, NAND, OR, NOR, XOR and XNOR, in that order.
- R2: Opcode 0x07 shifts A left by B and opcode 0x08 shifts A right by B, filling with zeros. A shift amount of 16 or more gives 0.
- R3: Add (0x09), sub (0x0a) and mul (0x0b) wrap modulo 2^16. A strobed add sets status bit 0 exactly when the wrapped sum is less than A. A strobed sub sets status bit 0 exactly when the wrapped difference is greater than A, which is a borrow.
- R4: Div (0x0c) and mod (0x0d) return the unsigned quotient and remainder. A strobed mul, div or mod clears status bit 0. Div or mod with B = 0 returns 0, clears the carry, and pulses `div_zero` high for one cycle after the strobe edge.
- R5: Opcode 0x0e returns 1 when A < B, 2 when A > B, and 0 when A equals B (unsigned).
- R6: Opcodes 0x0f to 0x14 are equal, not-equal, less, greater, less-or-equal and greater-or-equal (unsigned). Each returns 1 when its condition holds and 0 otherwise.
- R7: Opcode 0x15 returns 1 only when A equals 1. Opcode 0x16 returns 0 when A equals 1 and 1 otherwise.
- R8: A strobe with a valid opcode loads `comb_result` into `result_q` at the next edge. Operations other than add, sub, mul, div and mod leave the status register unchanged. No operation alters status bits 7:1.
- R9: A strobe with an opcode above 0x16 drives `bad_op` high for exactly the cycle after the edge. It leaves `result_q` and the status register unchanged, and `comb_result` reads 0 for such an opcode.
- R10: `reg_rd_data` is {8'h00, status} when `reg_sel` is 0xd and 0 for every other select. A write at 0xd loads `reg_wr_data[7:0]`, so writing 0 clears the register. A write at any other select has no effect.
- R11: When a status write and a strobed operation fall in the same cycle, the written value replaces the whole status register, including the carry. `result_q` still takes the operation's result.
- R12: A synchronous active-high reset clears `result_q`, the status register, `bad_op` and `div_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe, always accepted |
| op_code | input | 5 | Operation select |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| comb_result | output | 16 | Combinational result of the current opcode |
| result_q | output | 16 | Result register, loaded on a valid strobe |
| bad_op | output | 1 | One-cycle pulse after a strobe with an undefined opcode |
| div_zero | output | 1 | One-cycle pulse after a strobed div or mod with B = 0 |
| reg_sel | input | 4 | Register-port select; 0xd addresses the status register |
| reg_wr_en | input | 1 | Register-port write strobe |
| reg_wr_data | input | 16 | Register-port write data; bits 7:0 are used |
| reg_rd_data | output | 16 | Register-port read data |

## Verification
A status write and a strobed carry-affecting operation can land in the same cycle, and both then target status bit 0. The bench provokes this on purpose: it strobes an add that would set the carry while writing a value with bit 0 clear, and it strobes a mul while writing a value with bit 0 set. Its reference model gives the write priority over the whole register. After the edge it compares the status readback and the result register against that model, so a design that lets the carry update win, or drops the result load, is caught. Random traffic later mixes both kinds of access again, and the model is compared on every clock.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [4:0] {
    OP_NOT  = 5'h00, OP_AND  = 5'h01, OP_NAND = 5'h02, OP_OR   = 5'h03,
    OP_NOR  = 5'h04, OP_XOR  = 5'h05, OP_XNOR = 5'h06, OP_SHL  = 5'h07,
    OP_SHR  = 5'h08, OP_ADD  = 5'h09, OP_SUB  = 5'h0a, OP_MUL  = 5'h0b,
    OP_DIV  = 5'h0c, OP_MOD  = 5'h0d, OP_CMP3 = 5'h0e, OP_EQ   = 5'h0f,
    OP_NE   = 5'h10, OP_LT   = 5'h11, OP_GT   = 5'h12, OP_LE   = 5'h13,
    OP_GE   = 5'h14, OP_BOOL = 5'h15, OP_NBOOL = 5'h16
  } alu_op_e;

  localparam logic [4:0] OP_LAST = 5'h16;

  // what a strobed operation does to the carry bit
  typedef enum logic [1:0] {
    CY_KEEP  = 2'd0,
    CY_LOAD  = 2'd1,
    CY_CLEAR = 2'd2
  } carry_act_e;
endpackage

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         hit
);
  localparam int SHW = $clog2(W);

  // W is a power of two: any bit above the index range means amount >= W
  logic big_shift;
  assign big_shift = |b[W-1:SHW];

  always_comb begin
    hit = 1'b1;
    y   = '0;
    case (op)
      OP_NOT:  y = ~a;
      OP_AND:  y = a & b;
      OP_NAND: y = ~(a & b);
      OP_OR:   y = a | b;
      OP_NOR:  y = ~(a | b);
      OP_XOR:  y = a ^ b;
      OP_XNOR: y = ~(a ^ b);
      OP_SHL:  y = big_shift ? '0 : (a << b[SHW-1:0]);
      OP_SHR:  y = big_shift ? '0 : (a >> b[SHW-1:0]);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         hit,
  output carry_act_e   act,
  output logic         cy_new,
  output logic         dz
);
  logic [W-1:0] sum, diff, prod;
  logic         b_zero;

  assign sum    = a + b;
  assign diff   = a - b;
  assign prod   = a * b;
  assign b_zero = (b == '0);

  always_comb begin
    hit    = 1'b1;
    y      = '0;
    act    = CY_KEEP;
    cy_new = 1'b0;
    dz     = 1'b0;
    case (op)
      OP_ADD: begin
        y      = sum;
        act    = CY_LOAD;
        cy_new = (sum < a);
      end
      OP_SUB: begin
        y      = diff;
        act    = CY_LOAD;
        cy_new = (diff > a);
      end
      OP_MUL: begin
        y   = prod;
        act = CY_CLEAR;
      end
      OP_DIV: begin
        y   = b_zero ? '0 : (a / b);
        act = CY_CLEAR;
        dz  = b_zero;
      end
      OP_MOD: begin
        y   = b_zero ? '0 : (a % b);
        act = CY_CLEAR;
        dz  = b_zero;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_compare.sv
module alu16_compare
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         hit
);
  localparam int NPRED = 6;

  logic lt, gt, eq;
  logic [NPRED-1:0] pred;
  logic [4:0] pidx;

  assign lt = (a < b);
  assign gt = (a > b);
  assign eq = (a == b);

  // predicate order follows opcodes 0x0f upward
  assign pred = {~lt, ~gt, gt, lt, ~eq, eq};
  assign pidx = op - OP_EQ;

  always_comb begin
    hit = 1'b1;
    y   = '0;
    case (op)
      OP_CMP3: y = lt ? W'(1) : (gt ? W'(2) : '0);
      OP_EQ, OP_NE, OP_LT, OP_GT, OP_LE, OP_GE:
        y = W'(pred[pidx[2:0]]);
      OP_BOOL:  y = (a == W'(1)) ? W'(1) : '0;
      OP_NBOOL: y = (a == W'(1)) ? '0 : W'(1);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_status.sv
module alu16_status
  import alu16_pkg::*;
#(
  parameter int         W     = 16,
  parameter int         SW    = 8,
  parameter int         SEL_W = 4,
  parameter logic [3:0] ADDR  = 4'hd
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  carry_act_e       act,
  input  logic             cy_new,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_data,
  output logic [SW-1:0]    stat_q
);
  logic hit_addr;
  assign hit_addr = (sel == SEL_W'(ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (wr_en && hit_addr) begin
      stat_q <= wdata[SW-1:0];
    end else if (upd) begin
      case (act)
        CY_LOAD:  stat_q[0] <= cy_new;
        CY_CLEAR: stat_q[0] <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign rd_data = hit_addr ? {{(W-SW){1'b0}}, stat_q} : '0;
endmodule

// File: rtl/alu16_carry_unit.sv
module alu16_carry_unit
  import alu16_pkg::*;
#(
  parameter int         W     = 16,
  parameter int         SW    = 8,
  parameter int         SEL_W = 4,
  parameter logic [3:0] ADDR  = 4'hd
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [4:0]       op_code,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic [W-1:0]     comb_result,
  output logic [W-1:0]     result_q,
  output logic             bad_op,
  output logic             div_zero,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr_en,
  input  logic [W-1:0]     reg_wr_data,
  output logic [W-1:0]     reg_rd_data
);
  logic [W-1:0] log_y, ari_y, cmp_y;
  logic         log_hit, ari_hit, cmp_hit;
  carry_act_e   cy_act;
  logic         cy_new, ari_dz;
  logic         known;
  logic [SW-1:0] stat_q;

  alu16_logic #(.W(W)) u_logic (
    .op(op_code), .a(opa), .b(opb), .y(log_y), .hit(log_hit)
  );

  alu16_arith #(.W(W)) u_arith (
    .op(op_code), .a(opa), .b(opb), .y(ari_y), .hit(ari_hit),
    .act(cy_act), .cy_new(cy_new), .dz(ari_dz)
  );

  alu16_compare #(.W(W)) u_cmp (
    .op(op_code), .a(opa), .b(opb), .y(cmp_y), .hit(cmp_hit)
  );

  assign known       = (op_code <= OP_LAST);
  assign comb_result = known ? (log_y | ari_y | cmp_y) : '0;

  alu16_status #(.W(W), .SW(SW), .SEL_W(SEL_W), .ADDR(ADDR)) u_status (
    .clk(clk), .rst(rst), .upd(op_valid && known), .act(cy_act),
    .cy_new(cy_new), .sel(reg_sel), .wr_en(reg_wr_en),
    .wdata(reg_wr_data), .rd_data(reg_rd_data), .stat_q(stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      bad_op   <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      bad_op   <= op_valid && !known;
      div_zero <= op_valid && ari_dz;
      if (op_valid && known) result_q <= comb_result;
    end
  end
endmodule

// File: rtl/alu16_carry_unit_chk.sv
module alu16_carry_unit_chk
  import alu16_pkg::*;
#(
  parameter int         W     = 16,
  parameter int         SW    = 8,
  parameter int         SEL_W = 4,
  parameter logic [3:0] ADDR  = 4'hd
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [4:0]       op_code,
  input logic [W-1:0]     opb,
  input logic [W-1:0]     comb_result,
  input logic [W-1:0]     result_q,
  input logic             bad_op,
  input logic             div_zero,
  input logic [SEL_W-1:0] reg_sel,
  input logic             reg_wr_en,
  input logic [W-1:0]     reg_wr_data,
  input logic [SW-1:0]    stat_q
);
  logic st_wr, inval, clr_op, dv_op;
  assign st_wr  = reg_wr_en && (reg_sel == SEL_W'(ADDR));
  assign inval  = op_valid && (op_code > OP_LAST);
  assign clr_op = op_valid && (op_code == OP_MUL || op_code == OP_DIV || op_code == OP_MOD);
  assign dv_op  = op_valid && (op_code == OP_DIV || op_code == OP_MOD) && (opb == '0);

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (result_q == '0 && stat_q == '0 && !bad_op && !div_zero));

  a_r9_bad_pulse: assert property (@(posedge clk) disable iff (rst)
    inval |=> bad_op);

  a_r9_bad_quiet: assert property (@(posedge clk) disable iff (rst)
    !inval |=> !bad_op);

  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    inval |=> $stable(result_q));

  a_r8_latch: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= OP_LAST) |=> (result_q == $past(comb_result)));

  a_r8_upper_bits: assert property (@(posedge clk) disable iff (rst)
    !st_wr |=> (stat_q[SW-1:1] == $past(stat_q[SW-1:1])));

  a_r4_clear_carry: assert property (@(posedge clk) disable iff (rst)
    (clr_op && !st_wr) |=> !stat_q[0]);

  a_r4_div_zero: assert property (@(posedge clk) disable iff (rst)
    dv_op |=> (div_zero && result_q == '0));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    st_wr |=> (stat_q == $past(reg_wr_data[SW-1:0])));
endmodule

bind alu16_carry_unit alu16_carry_unit_chk #(
  .W(W), .SW(SW), .SEL_W(SEL_W), .ADDR(ADDR)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .opb(opb),
  .comb_result(comb_result), .result_q(result_q), .bad_op(bad_op),
  .div_zero(div_zero), .reg_sel(reg_sel), .reg_wr_en(reg_wr_en),
  .reg_wr_data(reg_wr_data), .stat_q(stat_q)
);

// File: tb/alu16_carry_unit_tb.sv
module alu16_carry_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [15:0] opa = '0, opb = '0;
  logic [15:0] comb_result, result_q, reg_rd_data;
  logic        bad_op, div_zero;
  logic [3:0]  reg_sel = 4'hd;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [15:0] m_res = '0;
  logic [7:0]  m_stat = '0;
  logic        m_bad = 1'b0, m_dz = 1'b0;

  always #2 clk = ~clk;

  alu16_carry_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .comb_result(comb_result), .result_q(result_q),
    .bad_op(bad_op), .div_zero(div_zero), .reg_sel(reg_sel),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  function automatic logic [15:0] ref_alu(int op, longint a, longint b);
    longint r;
    case (op)
      0:  r = ~a;
      1:  r = a & b;
      2:  r = ~(a & b);
      3:  r = a | b;
      4:  r = ~(a | b);
      5:  r = a ^ b;
      6:  r = ~(a ^ b);
      7:  r = (b >= 16) ? 0 : (a << b);
      8:  r = (b >= 16) ? 0 : (a >> b);
      9:  r = a + b;
      10: r = a - b;
      11: r = a * b;
      12: r = (b == 0) ? 0 : a / b;
      13: r = (b == 0) ? 0 : a % b;
      14: r = (a < b) ? 1 : ((a > b) ? 2 : 0);
      15: r = (a == b) ? 1 : 0;
      16: r = (a != b) ? 1 : 0;
      17: r = (a < b) ? 1 : 0;
      18: r = (a > b) ? 1 : 0;
      19: r = (a <= b) ? 1 : 0;
      20: r = (a >= b) ? 1 : 0;
      21: r = (a == 1) ? 1 : 0;
      22: r = (a == 1) ? 0 : 1;
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit v, int op, int a, int b,
                      bit we, int sel, int wd, string tag);
    longint la, lb;
    @(negedge clk);
    rst = r; op_valid = v; op_code = op[4:0]; opa = a[15:0]; opb = b[15:0];
    reg_wr_en = we; reg_sel = sel[3:0]; reg_wr_data = wd[15:0];
    la = a & 16'hffff; lb = b & 16'hffff;
    #1;
    if (v && !r) chk(tag, "comb_result", comb_result, ref_alu(op, la, lb));
    @(posedge clk);
    if (r) begin
      m_res = '0; m_stat = '0; m_bad = 0; m_dz = 0;
    end else begin
      m_bad = v && (op > 22);
      m_dz  = v && (op == 12 || op == 13) && (lb == 0);
      if (v && op <= 22) begin
        m_res = ref_alu(op, la, lb);
        if (op == 9)  m_stat[0] = (((la + lb) & 16'hffff) < la);
        if (op == 10) m_stat[0] = (((la - lb) & 16'hffff) > la);
        if (op >= 11 && op <= 13) m_stat[0] = 1'b0;
      end
      if (we && sel == 13) m_stat = wd[7:0];
    end
    #1;
    chk(tag, "result_q", result_q, m_res);
    chk(tag, "reg_rd_data", reg_rd_data, (sel == 13) ? {8'h00, m_stat} : 16'h0);
    chk(tag, "bad_op", bad_op, m_bad);
    chk(tag, "div_zero", div_zero, m_dz);
  endtask

  task automatic op1(int op, int a, int b, string tag);
    step(0, 1, op, a, b, 0, 13, 0, tag);
  endtask

  task automatic wstat(int wd, string tag);
    step(0, 0, 0, 0, 0, 1, 13, wd, tag);
  endtask

  function automatic int pick();
    int s = $urandom_range(0, 7);
    case (s)
      0: return 0;
      1: return 1;
      2: return 16'hffff;
      3: return 16'h8000;
      4: return $urandom_range(0, 20);
      default: return $urandom_range(0, 16'hffff);
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // R12: reset state
    step(1, 0, 0, 0, 0, 0, 13, 0, "R12");
    step(1, 0, 0, 0, 0, 0, 13, 0, "R12");

    // R1 logic operations
    op1(0, 16'h1234, 0, "R1");
    for (int k = 1; k <= 6; k++) op1(k, 16'hf0f0, 16'hff00, "R1");

    // R2 shifts and the 16-or-more boundary
    op1(7, 16'h0001, 15, "R2");
    op1(7, 16'h0001, 16, "R2");
    op1(8, 16'h8000, 15, "R2");
    op1(8, 16'h8000, 16'hffff, "R2");
    op1(7, 16'h00ff, 4, "R2");

    // R3 wrap and carry/borrow
    op1(9, 16'hffff, 1, "R3");
    op1(9, 1, 2, "R3");
    op1(10, 0, 1, "R3");
    op1(10, 5, 5, "R3");
    op1(11, 16'h0100, 16'h0100, "R3");
    op1(9, 16'h8000, 16'h8000, "R3");

    // R4 clear carry, div/mod, divide by zero
    op1(9, 16'hffff, 2, "R4");
    op1(11, 3, 4, "R4");
    op1(9, 16'hffff, 2, "R4");
    op1(12, 100, 0, "R4");
    op1(9, 16'hffff, 2, "R4");
    op1(13, 7, 0, "R4");
    op1(13, 7, 3, "R4");
    op1(12, 16'hffff, 16, "R4");

    // R5 three-way compare
    op1(14, 3, 9, "R5");
    op1(14, 9, 3, "R5");
    op1(14, 9, 9, "R5");

    // R6 predicates on equal, less and greater pairs
    for (int k = 15; k <= 20; k++) begin
      op1(k, 7, 7, "R6");
      op1(k, 2, 16'hffff, "R6");
      op1(k, 16'hffff, 2, "R6");
    end

    // R7 boolean test and negate
    op1(21, 1, 0, "R7");
    op1(21, 2, 0, "R7");
    op1(22, 1, 0, "R7");
    op1(22, 16'h0101, 0, "R7");

    // R8 non-arith ops keep status; upper bits untouched by the ALU
    op1(9, 16'hffff, 1, "R8");
    op1(1, 16'h00ff, 16'h0f0f, "R8");
    op1(14, 1, 2, "R8");
    wstat(16'h00fe, "R8");
    op1(9, 1, 1, "R8");
    op1(10, 0, 1, "R8");
    op1(11, 2, 2, "R8");

    // R9 undefined opcodes
    op1(9, 16'hffff, 1, "R9");
    op1(23, 5, 6, "R9");
    op1(31, 16'hffff, 16'hffff, "R9");
    step(0, 0, 0, 0, 0, 0, 13, 0, "R9");

    // R10 register port
    wstat(16'h12ab, "R10");
    step(0, 0, 0, 0, 0, 1, 3, 16'h0055, "R10");
    step(0, 0, 0, 0, 0, 0, 3, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 13, 0, "R10");
    wstat(0, "R10");

    // R11 write and strobe in the same cycle
    step(0, 1, 9, 16'hffff, 1, 1, 13, 16'h0040, "R11");
    step(0, 1, 11, 3, 3, 1, 13, 16'h0081, "R11");
    step(0, 1, 10, 0, 1, 1, 3, 16'h0000, "R11");

    // R12 mid-run reset
    step(1, 1, 9, 16'hffff, 1, 1, 13, 16'h00ff, "R12");
    step(0, 0, 0, 0, 0, 0, 13, 0, "R12");

    // random traffic, model compared every clock
    for (int n = 0; n < 600; n++) begin
      int op = ($urandom_range(0, 9) == 0) ? $urandom_range(23, 31)
                                           : $urandom_range(0, 22);
      bit we = ($urandom_range(0, 5) == 0);
      int sel = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 13;
      step(0, $urandom_range(0, 4) != 0, op, pick(), pick(),
           we, sel, $urandom_range(0, 16'hffff), "R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule